// File: doc/BRIEF.md
# Operand Addressing Mode Decoder

This block takes one instruction word of a 16-bit stack-oriented instruction set, the two words that may follow it, the eight general registers and the stack pointer. It splits the word into its opcode and two operand fields and turns each operand into a descriptor. A descriptor says whether the operand is a register, a memory location or a constant, and carries the register selector, the effective address or the constant value. The block also reports the final stack pointer, the total instruction length in words and the number of extra cycles spent fetching operand words. It does not read or write registers or memory; an execute stage uses the descriptors to do that.

The decoded result is registered. A word presented with `inValid` high appears on the outputs one clock later, with `outValid` high. The source operand (field a, 6 bits) is resolved against the incoming stack pointer. The destination operand (field b, 5 bits) is resolved against the stack pointer as the source operand left it.

Top module: `opdec_top`

## Requirements
- R1: On a rising edge where `inValid` is high, every decoded output is loaded and `outValid` is high for the next cycle. On an edge where `inValid` is low, `outValid` goes low and every other output holds its value. During reset every output is zero.
- R2: `opcode` is instruction bits 4:0, `fieldB` is bits 9:5 and `fieldA` is bits 15:10.
- R3: Kind encoding is 0 none, 1 register, 2 memory, 3 literal. Selectors 0..7 name the general registers in their order on `gprFlat`, and 8, 9, 10 name SP, PC and EX. Codes 0x00..0x07 are kind 1 with selector equal to the code. Codes 0x08..0x0F are kind 2 at the address held in general register (code & 7).
- R4: Codes 0x10..0x17 are kind 2 at the operand's extra word plus general register (code & 7), modulo 2^16, and consume one extra word.
- R5: Code 0x18 in field b is a push: kind 2 at (stack pointer seen by b) - 1, and the stack pointer drops by one. In field a it is a pop: kind 2 at `spIn`, and the stack pointer rises by one.
- R6: Code 0x19 is kind 2 at the stack pointer seen by the operand. Code 0x1A is kind 2 at that stack pointer plus the extra word, and consumes a word.
- R7: Codes 0x1B, 0x1C, 0x1D are kind 1 with selectors 8, 9, 10. Code 0x1E is kind 2 at the extra word. Code 0x1F is kind 3 with value equal to the extra word. Both 0x1E and 0x1F consume a word.
- R8: Field a codes 0x20..0x3F are kind 3 with value (code & 0x1F) - 1 modulo 2^16, which covers 0xFFFF up to 0x001E, and consume no word.
- R9: When `opcode` is zero, field b is an extended opcode: `bKind` is 0 and b consumes no word, while field a is still decoded as an operand.
- R10: `extraCycles` equals the number of operands that consume a word, and `instrLen` is that number plus one. The b operand's extra word is `nextWord0`. The a operand's extra word is `nextWord1` when b consumes a word, otherwise `nextWord0`.
- R11: Field a sees `spIn`. Field b sees `spIn` after a's adjustment. `spOut` is the value after both adjustments, modulo 2^16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low synchronous reset |
| inValid | input | 1 | the input word and its context are to be decoded |
| instrWord | input | 16 | first instruction word |
| nextWord0 | input | 16 | word after the instruction word |
| nextWord1 | input | 16 | second word after the instruction word |
| gprFlat | input | 128 | eight general registers, register k in bits 16k+15:16k |
| spIn | input | 16 | current stack pointer |
| outValid | output | 1 | decoded result is fresh this cycle |
| opcode | output | 5 | opcode field |
| fieldB | output | 5 | destination / extended-opcode field |
| fieldA | output | 6 | source field |
| instrLen | output | 2 | instruction length in words (1..3) |
| extraCycles | output | 2 | cycles spent on extra operand words |
| aKind | output | 2 | source operand kind |
| aSel | output | 4 | source register selector |
| aValue | output | 16 | source address or literal |
| bKind | output | 2 | destination operand kind |
| bSel | output | 4 | destination register selector |
| bValue | output | 16 | destination address or literal |
| spOut | output | 16 | stack pointer after both operands |

## Verification
A wrong mode classification inside the control shows on the port one cycle after the word is accepted. It shows as a wrong kind or selector, or as an instruction length that disagrees with the operand words actually used. The bench sweeps every a code against every b code in both extended and basic form. The registers, stack pointer (including wrap at 0 and 0xFFFF) and extra words vary from case to case, so a wrong operand index, word choice or stack ordering gives a mismatched address or `spOut` in that same case.

// File: rtl/opdec_pkg.sv
package opdec_pkg;
  localparam int DATA_W = 16;
  localparam int OPC_W  = 5;
  localparam int BF_W   = 5;
  localparam int AF_W   = DATA_W - OPC_W - BF_W;
  localparam int NGPR   = 8;
  localparam int GIDX_W = $clog2(NGPR);
  localparam int SEL_W  = GIDX_W + 1;
  localparam int LIT_W  = AF_W - 1;

  localparam logic [SEL_W-1:0] SEL_SP = SEL_W'(8);
  localparam logic [SEL_W-1:0] SEL_PC = SEL_W'(9);
  localparam logic [SEL_W-1:0] SEL_EX = SEL_W'(10);

  typedef enum logic [1:0] {K_NONE = 2'd0, K_REG = 2'd1, K_MEM = 2'd2, K_LIT = 2'd3} opKind_e;

  typedef enum logic [3:0] {
    M_NONE, M_GPR, M_IND, M_IDX, M_PUSH, M_POP, M_PEEK, M_PICK,
    M_SPR, M_ABS, M_NLIT, M_SLIT
  } opMode_e;

  typedef struct packed {
    opMode_e          mode;
    logic [SEL_W-1:0] sel;
    logic             takesWord;
    logic [LIT_W-1:0] lit;
  } opStrobe_t;

  typedef struct packed {
    opStrobe_t a;
    opStrobe_t b;
    logic      aWordHi;
  } ctrlStrobes_t;

  typedef struct packed {
    opKind_e           kind;
    logic [SEL_W-1:0]  sel;
    logic [DATA_W-1:0] value;
    logic [DATA_W-1:0] spNext;
  } resolved_t;
endpackage

// File: rtl/opdec_ctrl.sv
module opdec_ctrl
  import opdec_pkg::*;
(
  input  logic [DATA_W-1:0] instrWord,
  output logic [OPC_W-1:0]  opcode,
  output logic [BF_W-1:0]   fieldB,
  output logic [AF_W-1:0]   fieldA,
  output ctrlStrobes_t      strobes
);
  function automatic opStrobe_t classify(input logic [AF_W-1:0] code, input logic isA);
    opStrobe_t s;
    s = '0;
    s.mode = M_NONE;
    s.sel = {1'b0, code[GIDX_W-1:0]};
    if (code[AF_W-1]) begin
      s.mode = M_SLIT;
      s.lit = code[LIT_W-1:0];
    end else begin
      case (code[4:3])
        2'b00: s.mode = M_GPR;
        2'b01: s.mode = M_IND;
        2'b10: begin s.mode = M_IDX; s.takesWord = 1'b1; end
        default: begin
          case (code[2:0])
            3'd0: s.mode = isA ? M_POP : M_PUSH;
            3'd1: s.mode = M_PEEK;
            3'd2: begin s.mode = M_PICK; s.takesWord = 1'b1; end
            3'd3: begin s.mode = M_SPR; s.sel = SEL_SP; end
            3'd4: begin s.mode = M_SPR; s.sel = SEL_PC; end
            3'd5: begin s.mode = M_SPR; s.sel = SEL_EX; end
            3'd6: begin s.mode = M_ABS; s.takesWord = 1'b1; end
            default: begin s.mode = M_NLIT; s.takesWord = 1'b1; end
          endcase
        end
      endcase
    end
    return s;
  endfunction

  assign opcode = instrWord[OPC_W-1:0];
  assign fieldB = instrWord[OPC_W+BF_W-1:OPC_W];
  assign fieldA = instrWord[DATA_W-1:OPC_W+BF_W];

  always_comb begin
    strobes.a = classify(fieldA, 1'b1);
    if (opcode == '0) begin
      strobes.b = '0;
      strobes.b.mode = M_NONE;
    end else begin
      strobes.b = classify({{(AF_W-BF_W){1'b0}}, fieldB}, 1'b0);
    end
    strobes.aWordHi = strobes.b.takesWord;
  end
endmodule

// File: rtl/opdec_dp.sv
module opdec_dp
  import opdec_pkg::*;
(
  input  ctrlStrobes_t           strobes,
  input  logic [DATA_W-1:0]      nextWord0,
  input  logic [DATA_W-1:0]      nextWord1,
  input  logic [NGPR*DATA_W-1:0] gprFlat,
  input  logic [DATA_W-1:0]      spIn,
  output resolved_t              aRes,
  output resolved_t              bRes,
  output logic [1:0]             extraCycles,
  output logic [1:0]             instrLen
);
  logic [DATA_W-1:0] gpr [NGPR];
  logic [DATA_W-1:0] aWord;

  for (genvar g = 0; g < NGPR; g++) begin : g_unpack
    assign gpr[g] = gprFlat[g*DATA_W +: DATA_W];
  end

  function automatic resolved_t resolve(input opStrobe_t s, input logic [DATA_W-1:0] word,
                                        input logic [DATA_W-1:0] spBase,
                                        input logic [DATA_W-1:0] rv);
    resolved_t r;
    r.kind = K_NONE;
    r.sel = '0;
    r.value = '0;
    r.spNext = spBase;
    case (s.mode)
      M_GPR:  begin r.kind = K_REG; r.sel = s.sel; end
      M_SPR:  begin r.kind = K_REG; r.sel = s.sel; end
      M_IND:  begin r.kind = K_MEM; r.value = rv; end
      M_IDX:  begin r.kind = K_MEM; r.value = word + rv; end
      M_PUSH: begin r.kind = K_MEM; r.value = spBase - 1'b1; r.spNext = spBase - 1'b1; end
      M_POP:  begin r.kind = K_MEM; r.value = spBase; r.spNext = spBase + 1'b1; end
      M_PEEK: begin r.kind = K_MEM; r.value = spBase; end
      M_PICK: begin r.kind = K_MEM; r.value = spBase + word; end
      M_ABS:  begin r.kind = K_MEM; r.value = word; end
      M_NLIT: begin r.kind = K_LIT; r.value = word; end
      M_SLIT: begin r.kind = K_LIT; r.value = DATA_W'(s.lit) - 1'b1; end
      default: r.kind = K_NONE;
    endcase
    return r;
  endfunction

  assign aWord = strobes.aWordHi ? nextWord1 : nextWord0;

  always_comb begin
    aRes = resolve(strobes.a, aWord, spIn, gpr[strobes.a.sel[GIDX_W-1:0]]);
    bRes = resolve(strobes.b, nextWord0, aRes.spNext, gpr[strobes.b.sel[GIDX_W-1:0]]);
    extraCycles = {1'b0, strobes.a.takesWord} + {1'b0, strobes.b.takesWord};
    instrLen = extraCycles + 2'd1;
  end
endmodule

// File: rtl/opdec_top.sv
module opdec_top
  import opdec_pkg::*;
(
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   inValid,
  input  logic [DATA_W-1:0]      instrWord,
  input  logic [DATA_W-1:0]      nextWord0,
  input  logic [DATA_W-1:0]      nextWord1,
  input  logic [NGPR*DATA_W-1:0] gprFlat,
  input  logic [DATA_W-1:0]      spIn,
  output logic                   outValid,
  output logic [OPC_W-1:0]       opcode,
  output logic [BF_W-1:0]        fieldB,
  output logic [AF_W-1:0]        fieldA,
  output logic [1:0]             instrLen,
  output logic [1:0]             extraCycles,
  output logic [1:0]             aKind,
  output logic [SEL_W-1:0]       aSel,
  output logic [DATA_W-1:0]      aValue,
  output logic [1:0]             bKind,
  output logic [SEL_W-1:0]       bSel,
  output logic [DATA_W-1:0]      bValue,
  output logic [DATA_W-1:0]      spOut
);
  logic [OPC_W-1:0] opcodeC;
  logic [BF_W-1:0]  fieldBC;
  logic [AF_W-1:0]  fieldAC;
  ctrlStrobes_t     strobes;
  resolved_t        aRes, bRes;
  logic [1:0]       extraC, lenC;

  opdec_ctrl u_ctrl (
    .instrWord(instrWord), .opcode(opcodeC), .fieldB(fieldBC),
    .fieldA(fieldAC), .strobes(strobes)
  );

  opdec_dp u_dp (
    .strobes(strobes), .nextWord0(nextWord0), .nextWord1(nextWord1),
    .gprFlat(gprFlat), .spIn(spIn), .aRes(aRes), .bRes(bRes),
    .extraCycles(extraC), .instrLen(lenC)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      outValid <= 1'b0;
      opcode <= '0; fieldB <= '0; fieldA <= '0;
      instrLen <= '0; extraCycles <= '0;
      aKind <= '0; aSel <= '0; aValue <= '0;
      bKind <= '0; bSel <= '0; bValue <= '0;
      spOut <= '0;
    end else begin
      outValid <= inValid;
      if (inValid) begin
        opcode <= opcodeC; fieldB <= fieldBC; fieldA <= fieldAC;
        instrLen <= lenC; extraCycles <= extraC;
        aKind <= aRes.kind; aSel <= aRes.sel; aValue <= aRes.value;
        bKind <= bRes.kind; bSel <= bRes.sel; bValue <= bRes.value;
        spOut <= bRes.spNext;
      end
    end
  end
endmodule

// File: rtl/opdec_chk.sv
module opdec_chk
  import opdec_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              inValid,
  input logic              outValid,
  input logic [OPC_W-1:0]  opcode,
  input logic [BF_W-1:0]   fieldB,
  input logic [AF_W-1:0]   fieldA,
  input logic [1:0]        instrLen,
  input logic [1:0]        extraCycles,
  input logic [1:0]        aKind,
  input logic [SEL_W-1:0]  aSel,
  input logic [DATA_W-1:0] aValue,
  input logic [1:0]        bKind,
  input logic [SEL_W-1:0]  bSel,
  input logic [DATA_W-1:0] spOut
);
  p_accept_r1: assert property (@(posedge clk) disable iff (!rst_n) inValid |=> outValid);
  p_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !inValid |=> (!outValid && $stable(aValue) && $stable(spOut) && $stable(instrLen)));
  p_len_r10: assert property (@(posedge clk) disable iff (!rst_n)
    outValid |-> (instrLen != 2'd0 && instrLen == 2'(extraCycles + 2'd1)));
  p_ext_none_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (outValid && opcode == '0) |-> (bKind == 2'd0 && instrLen <= 2'd2));
  p_short_lit_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (outValid && fieldA[AF_W-1]) |-> (aKind == 2'd3 && aValue == DATA_W'(fieldA[LIT_W-1:0]) - 16'd1));
  p_gpr_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (outValid && fieldA[5:3] == 3'b000) |-> (aKind == 2'd1 && aSel == {1'b0, fieldA[2:0]}));
  p_pc_sel_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (outValid && opcode != '0 && fieldB == 5'h1C) |-> (bKind == 2'd1 && bSel == SEL_PC));
endmodule

bind opdec_top opdec_chk u_chk (
  .clk(clk), .rst_n(rst_n), .inValid(inValid), .outValid(outValid),
  .opcode(opcode), .fieldB(fieldB), .fieldA(fieldA), .instrLen(instrLen),
  .extraCycles(extraCycles), .aKind(aKind), .aSel(aSel), .aValue(aValue),
  .bKind(bKind), .bSel(bSel), .spOut(spOut)
);

// File: tb/sim_opdec_top.sv
module sim_opdec_top;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         inValid = 1'b0;
  logic [15:0]  instrWord = '0, nextWord0 = '0, nextWord1 = '0, spIn = '0;
  logic [127:0] gprFlat = '0;
  logic         outValid;
  logic [4:0]   opcode, fieldB;
  logic [5:0]   fieldA;
  logic [1:0]   instrLen, extraCycles, aKind, bKind;
  logic [3:0]   aSel, bSel;
  logic [15:0]  aValue, bValue, spOut;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  opdec_top u0 (
    .clk(clk), .rst_n(rst_n), .inValid(inValid), .instrWord(instrWord),
    .nextWord0(nextWord0), .nextWord1(nextWord1), .gprFlat(gprFlat), .spIn(spIn),
    .outValid(outValid), .opcode(opcode), .fieldB(fieldB), .fieldA(fieldA),
    .instrLen(instrLen), .extraCycles(extraCycles), .aKind(aKind), .aSel(aSel),
    .aValue(aValue), .bKind(bKind), .bSel(bSel), .bValue(bValue), .spOut(spOut)
  );

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // reference from the requirement text
  task automatic model(input logic [5:0] code, input bit isA, input bit active,
                       input logic [15:0] word, input logic [15:0] spBase,
                       input logic [15:0] rv, output logic [1:0] kind,
                       output logic [3:0] sel, output logic [15:0] val,
                       output logic [15:0] spNext, output bit takes, output string tag);
    kind = 2'd0; sel = 4'd0; val = 16'd0; spNext = spBase; takes = 1'b0;
    if (!active) begin
      tag = "R9";
    end else if (code < 6'h08) begin
      tag = "R3"; kind = 2'd1; sel = code[3:0];
    end else if (code < 6'h10) begin
      tag = "R3"; kind = 2'd2; val = rv;
    end else if (code < 6'h18) begin
      tag = "R4"; kind = 2'd2; val = word + rv; takes = 1'b1;
    end else if (code == 6'h18) begin
      tag = "R5"; kind = 2'd2;
      if (isA) begin val = spBase; spNext = spBase + 16'd1; end
      else begin val = spBase - 16'd1; spNext = spBase - 16'd1; end
    end else if (code == 6'h19) begin
      tag = "R6"; kind = 2'd2; val = spBase;
    end else if (code == 6'h1A) begin
      tag = "R6"; kind = 2'd2; val = spBase + word; takes = 1'b1;
    end else if (code < 6'h1E) begin
      tag = "R7"; kind = 2'd1; sel = 4'(code - 6'h1B + 6'd8);
    end else if (code == 6'h1E) begin
      tag = "R7"; kind = 2'd2; val = word; takes = 1'b1;
    end else if (code == 6'h1F) begin
      tag = "R7"; kind = 2'd3; val = word; takes = 1'b1;
    end else begin
      tag = "R8"; kind = 2'd3; val = 16'({11'd0, code[4:0]}) - 16'd1;
    end
  endtask

  initial begin
    #(200000 * 4);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [15:0] gpr [8];
    logic [1:0]  ka, kb;
    logic [3:0]  sa, sb;
    logic [15:0] va, vb, spA, spB, wa, holdA, holdSp;
    bit          ta, tb, tb0;
    string       tga, tgb;
    int          n;
    logic [4:0]  op;
    logic [1:0]  extra;

    repeat (3) @(negedge clk);
    chk(outValid == 1'b0, "R1", "reset outValid", 16'(outValid), 16'd0);
    chk(aValue == 16'd0 && spOut == 16'd0 && instrLen == 2'd0, "R1", "reset outputs",
        aValue | spOut | 16'(instrLen), 16'd0);
    rst_n = 1'b1;

    n = 0;
    for (int ext = 0; ext < 2; ext++) begin
      for (int b = 0; b < 32; b++) begin
        for (int a = 0; a < 64; a++) begin
          op = (ext == 0) ? 5'd0 : 5'(1 + (n % 31));
          for (int g = 0; g < 8; g++) gpr[g] = 16'(g * 16'h0101 + n * 7);
          case (n % 4)
            0: spIn = 16'h0000;
            1: spIn = 16'hFFFF;
            2: spIn = 16'h8000;
            default: spIn = 16'(n * 13);
          endcase
          nextWord0 = 16'hA000 ^ 16'(n);
          nextWord1 = 16'h5000 + 16'(n);
          for (int g = 0; g < 8; g++) gprFlat[g*16 +: 16] = gpr[g];
          instrWord = {6'(a), 5'(b), op};
          inValid = 1'b1;
          // b consumes a word only for basic opcodes
          model({1'b0, 5'(b)}, 1'b0, op != 0, 16'd0, 16'd0, 16'd0, kb, sb, vb, spB, tb0, tgb);
          wa = tb0 ? nextWord1 : nextWord0;
          model(6'(a), 1'b1, 1'b1, wa, spIn, gpr[a % 8], ka, sa, va, spA, ta, tga);
          model({1'b0, 5'(b)}, 1'b0, op != 0, nextWord0, spA, gpr[b % 8], kb, sb, vb, spB, tb, tgb);
          extra = 2'(ta) + 2'(tb);
          @(negedge clk);
          chk(outValid == 1'b1, "R1", "outValid", 16'(outValid), 16'd1);
          chk(opcode == op && fieldB == 5'(b) && fieldA == 6'(a), "R2", "fields",
              {fieldA, fieldB, opcode}, {6'(a), 5'(b), op});
          chk(instrLen == extra + 2'd1, "R10", "instrLen", 16'(instrLen), 16'(extra + 2'd1));
          chk(extraCycles == extra, "R10", "extraCycles", 16'(extraCycles), 16'(extra));
          chk(spOut == spB, "R11", "spOut", spOut, spB);
          chk(aKind == ka, tga, "aKind", 16'(aKind), 16'(ka));
          if (ka == 2'd1) chk(aSel == sa, tga, "aSel", 16'(aSel), 16'(sa));
          if (ka >= 2'd2) chk(aValue == va, tga, "aValue", aValue, va);
          chk(bKind == kb, tgb, "bKind", 16'(bKind), 16'(kb));
          if (kb == 2'd1) chk(bSel == sb, tgb, "bSel", 16'(bSel), 16'(sb));
          if (kb >= 2'd2) chk(bValue == vb, tgb, "bValue", bValue, vb);
          n++;
        end
      end
    end

    // hold behaviour: new inputs with inValid low must not reach the outputs (R1)
    holdA = aValue;
    holdSp = spOut;
    inValid = 1'b0;
    instrWord = {6'h1A, 5'h18, 5'd2};
    spIn = 16'h1357;
    nextWord0 = 16'h2222;
    @(negedge clk);
    chk(outValid == 1'b0, "R1", "outValid idle", 16'(outValid), 16'd0);
    @(negedge clk);
    chk(aValue == holdA, "R1", "aValue hold", aValue, holdA);
    chk(spOut == holdSp, "R1", "spOut hold", spOut, holdSp);

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule